// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing for a display transmitter. Running on the pixel clock, it keeps a pixel counter and a line counter and decodes them into horizontal sync, vertical sync, data-enable and a field flag. It handles both progressive and interlaced rasters. Every window is set by a static configuration bus. The bus covers line length, active start, sync edges, sync polarities, a vertical active window and a vertical sync window for each field, an interlace switch, and a pixel offset. That offset places the second field's vsync edges in the middle of a line.

The configuration goes through a shadow register. The shadow loads while the generator is disabled and at the wrap from the last pixel of a frame to pixel 0 of line 0. A host can therefore rewrite the bus at any time, and the raster changes only on a frame boundary. Outputs are registered. The value seen after a clock edge describes the counter position the generator held before that edge. The first edge with enable high therefore presents pixel 0 of line 0.

Top module: `raster_tgen`

## Requirements
- R1: While `en` is low, the counters return to pixel 0 of line 0. After the next edge `de_o` and `field_o` are 0, and each sync output sits at its inactive level, which equals its polarity bit. During reset every output is 0. After enable rises, the first output cycle shows pixel 0 of line 0.
- R2: Pixels of a line are numbered 0 to `cfg_line_len`-1. Horizontal sync is asserted for pixels p with `cfg_hs_beg` <= p < `cfg_hs_end`.
- R3: Data-enable is asserted only for pixels p with `cfg_hact_beg` <= p, so the active region ends at the end of the line.
- R4: In progressive mode (`cfg_ilace`=0) a frame has `cfg_f0_vact_end` lines. Vertical sync is asserted for whole lines l with `cfg_f0_vs_beg` <= l < `cfg_f0_vs_end`, starting at pixel 0.
- R5: In progressive mode data-enable requires line l with `cfg_f0_vact_beg` <= l < `cfg_f0_vact_end`. The second-field settings have no effect.
- R6: A polarity bit of 0 makes its sync output active high. A bit of 1 makes it active low.
- R7: In interlaced mode a frame has `cfg_f1_vact_end` lines. `field_o` is 0 for lines below `cfg_f0_vact_end` and 1 from that line on. In progressive mode it stays 0.
- R8: While `field_o` is 1, data-enable uses only the second window `cfg_f1_vact_beg` <= l < `cfg_f1_vact_end`. While it is 0, only the first window applies.
- R9: In the second field, vertical sync rises at pixel `cfg_hs_beg`+`cfg_f1_vs_off` of line `cfg_f1_vs_beg`. It falls at the same pixel of line `cfg_f1_vs_end`. In the first field only the first-field sync window applies.
- R10: A configuration change made while enabled has no effect until the current frame has completed. The new values apply from pixel 0 of line 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the raster at its origin |
| cfg_line_len | input | HCNT_W | Pixels per line, also the end of horizontal active |
| cfg_hact_beg | input | HCNT_W | First active pixel of a line |
| cfg_hs_beg | input | HCNT_W | First pixel of horizontal sync |
| cfg_hs_end | input | HCNT_W | Pixel where horizontal sync ends |
| cfg_f1_vs_off | input | HCNT_W | Offset added to `cfg_hs_beg` for second-field vsync edges |
| cfg_f0_vact_beg | input | VCNT_W | First active line of field 0 |
| cfg_f0_vact_end | input | VCNT_W | End of field-0 active; frame length when progressive |
| cfg_f0_vs_beg | input | VCNT_W | First vsync line of field 0 |
| cfg_f0_vs_end | input | VCNT_W | Line where field-0 vsync ends |
| cfg_f1_vact_beg | input | VCNT_W | First active line of field 1 |
| cfg_f1_vact_end | input | VCNT_W | End of field-1 active; frame length when interlaced |
| cfg_f1_vs_beg | input | VCNT_W | Line on which field-1 vsync starts |
| cfg_f1_vs_end | input | VCNT_W | Line on which field-1 vsync ends |
| cfg_hs_pol | input | 1 | Horizontal sync polarity, 1 = active low |
| cfg_vs_pol | input | 1 | Vertical sync polarity, 1 = active low |
| cfg_ilace | input | 1 | 1 selects the interlaced raster |
| hsync_o | output | 1 | Horizontal sync at the configured polarity |
| vsync_o | output | 1 | Vertical sync at the configured polarity |
| de_o | output | 1 | Data-enable |
| field_o | output | 1 | Field flag, 0 first field, 1 second field |

## Verification
The bench rewrites the line length and the windows in the middle of a frame. A generator that loaded its configuration straight from the bus would shorten the current line or frame at once, and the sync and enable positions would slip. The interlaced scenario puts the second-field vsync edges in mid-line. A design that switched that sync on line boundaries would be wrong by a dozen pixels on two lines. The scenario also confirms that field 0's active window never opens during field 1, and that the field flag changes exactly at the end of the first active window. Dropping enable in mid-frame and raising it again checks that output restarts at pixel 0. It also checks that both sync outputs rest at their inactive levels while disabled, and that inverting the polarity bits flips only the asserted level.

// File: rtl/raster_tgen_pkg.sv
package raster_tgen_pkg;

   // Narrowest and widest counters the library accepts
   localparam int MIN_CNT_W = 4;
   localparam int MAX_CNT_W = 16;

   // Logical (polarity-free) timing flags for one pixel position
   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
      logic fld;
   } tg_flags_t;

   // Field identifiers as carried on the field flag
   typedef enum logic {
      FIELD_FIRST  = 1'b0,
      FIELD_SECOND = 1'b1
   } field_e;

   // Map an asserted/deasserted condition to a pin level (pol 1 = active low)
   function automatic logic pin_level(input logic asserted, input logic pol);
      return asserted ^ pol;
   endfunction

endpackage

// File: rtl/raster_cfg_shadow.sv
module raster_cfg_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("raster_cfg_shadow: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

   // Configuration only moves on a load strobe
   p_shadow_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
   parameter int HCNT_W = 12,
   parameter int VCNT_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HCNT_W-1:0] line_len,
   input  logic [VCNT_W-1:0] frame_len,
   output logic [HCNT_W-1:0] h_o,
   output logic [VCNT_W-1:0] v_o,
   output logic              frame_last_o
);

   import raster_tgen_pkg::*;

   localparam logic [HCNT_W-1:0] H_ONE = HCNT_W'(1);
   localparam logic [VCNT_W-1:0] V_ONE = VCNT_W'(1);

   if (HCNT_W < MIN_CNT_W || HCNT_W > MAX_CNT_W) begin : g_bad_h
      $error("raster_counter: HCNT_W out of range");
   end
   if (VCNT_W < MIN_CNT_W || VCNT_W > MAX_CNT_W) begin : g_bad_v
      $error("raster_counter: VCNT_W out of range");
   end

   logic [HCNT_W-1:0] h_q;
   logic [VCNT_W-1:0] v_q;
   logic              line_last;

   always_comb begin
      line_last    = (h_q == line_len - H_ONE);
      frame_last_o = line_last && (v_q == frame_len - V_ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= '0;
         v_q <= '0;
      end else if (!run) begin
         h_q <= '0;
         v_q <= '0;
      end else if (line_last) begin
         h_q <= '0;
         v_q <= frame_last_o ? '0 : v_q + V_ONE;
      end else begin
         h_q <= h_q + H_ONE;
      end
   end

   assign h_o = h_q;
   assign v_o = v_q;

   // Pixel counter steps by one inside a line
   p_hstep_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      run && !line_last |=> h_q == $past(h_q) + H_ONE);

   // Last pixel of a line returns to pixel 0
   p_hwrap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      run && line_last |=> h_q == '0);

   // Last pixel of a frame returns to the origin
   p_vwrap_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      run && frame_last_o |=> (h_q == '0 && v_q == '0));

   // Disabled raster sits at the origin
   p_idle_origin_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (h_q == '0 && v_q == '0));

endmodule

// File: rtl/raster_decode.sv
module raster_decode #(
   parameter int HCNT_W   = 12,
   parameter int VCNT_W   = 11,
   parameter bit ILACE_EN = 1'b1
) (
   input  logic [HCNT_W-1:0]       h,
   input  logic [VCNT_W-1:0]       v,
   input  logic [HCNT_W-1:0]       hact_beg,
   input  logic [HCNT_W-1:0]       hs_beg,
   input  logic [HCNT_W-1:0]       hs_end,
   input  logic [HCNT_W-1:0]       f1_vs_off,
   input  logic [VCNT_W-1:0]       f0_vact_beg,
   input  logic [VCNT_W-1:0]       f0_vact_end,
   input  logic [VCNT_W-1:0]       f0_vs_beg,
   input  logic [VCNT_W-1:0]       f0_vs_end,
   input  logic [VCNT_W-1:0]       f1_vact_beg,
   input  logic [VCNT_W-1:0]       f1_vact_end,
   input  logic [VCNT_W-1:0]       f1_vs_beg,
   input  logic [VCNT_W-1:0]       f1_vs_end,
   input  logic                    ilace,
   output raster_tgen_pkg::tg_flags_t flags
);

   import raster_tgen_pkg::*;

   logic h_act;
   logic h_sync;
   logic v_act_f0;
   logic v_sync_f0;
   logic second;
   logic v_act_f1;
   logic v_sync_f1;

   // Horizontal windows and first-field vertical windows
   always_comb begin
      h_act     = (h >= hact_beg);
      h_sync    = (h >= hs_beg) && (h < hs_end);
      v_act_f0  = (v >= f0_vact_beg) && (v < f0_vact_end);
      v_sync_f0 = (v >= f0_vs_beg) && (v < f0_vs_end);
   end

   if (ILACE_EN) begin : g_two_field
      logic [HCNT_W:0] mid_px;
      logic            past_rise;
      logic            before_fall;

      always_comb begin
         mid_px      = {1'b0, hs_beg} + {1'b0, f1_vs_off};
         second      = ilace && (v >= f0_vact_end);
         v_act_f1    = (v >= f1_vact_beg) && (v < f1_vact_end);
         past_rise   = (v > f1_vs_beg) ||
                       ((v == f1_vs_beg) && ({1'b0, h} >= mid_px));
         before_fall = (v < f1_vs_end) ||
                       ((v == f1_vs_end) && ({1'b0, h} < mid_px));
         v_sync_f1   = past_rise && before_fall;
      end
   end else begin : g_one_field
      assign second    = 1'b0;
      assign v_act_f1  = 1'b0;
      assign v_sync_f1 = 1'b0;
   end

   always_comb begin
      flags.hs  = h_sync;
      flags.fld = second;
      flags.de  = h_act && (second ? v_act_f1 : v_act_f0);
      flags.vs  = second ? v_sync_f1 : v_sync_f0;
   end

endmodule

// File: rtl/raster_tgen.sv
module raster_tgen #(
   parameter int HCNT_W   = 12,
   parameter int VCNT_W   = 11,
   parameter bit ILACE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HCNT_W-1:0] cfg_line_len,
   input  logic [HCNT_W-1:0] cfg_hact_beg,
   input  logic [HCNT_W-1:0] cfg_hs_beg,
   input  logic [HCNT_W-1:0] cfg_hs_end,
   input  logic [HCNT_W-1:0] cfg_f1_vs_off,
   input  logic [VCNT_W-1:0] cfg_f0_vact_beg,
   input  logic [VCNT_W-1:0] cfg_f0_vact_end,
   input  logic [VCNT_W-1:0] cfg_f0_vs_beg,
   input  logic [VCNT_W-1:0] cfg_f0_vs_end,
   input  logic [VCNT_W-1:0] cfg_f1_vact_beg,
   input  logic [VCNT_W-1:0] cfg_f1_vact_end,
   input  logic [VCNT_W-1:0] cfg_f1_vs_beg,
   input  logic [VCNT_W-1:0] cfg_f1_vs_end,
   input  logic              cfg_hs_pol,
   input  logic              cfg_vs_pol,
   input  logic              cfg_ilace,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              field_o
);

   import raster_tgen_pkg::*;

   localparam int H_FIELDS = 5;
   localparam int V_FIELDS = 8;
   localparam int FLAG_BITS = 3;
   localparam int CFG_W = H_FIELDS * HCNT_W + V_FIELDS * VCNT_W + FLAG_BITS;

   if (HCNT_W < MIN_CNT_W || HCNT_W > MAX_CNT_W) begin : g_bad_h
      $error("raster_tgen: HCNT_W out of range");
   end
   if (VCNT_W < MIN_CNT_W || VCNT_W > MAX_CNT_W) begin : g_bad_v
      $error("raster_tgen: VCNT_W out of range");
   end

   // ---------------- configuration shadow ----------------
   logic [CFG_W-1:0] cfg_bus;
   logic [CFG_W-1:0] cfg_q;
   logic             frame_last;
   logic             shadow_load;

   logic [HCNT_W-1:0] s_line_len, s_hact_beg, s_hs_beg, s_hs_end, s_f1_vs_off;
   logic [VCNT_W-1:0] s_f0_vact_beg, s_f0_vact_end, s_f0_vs_beg, s_f0_vs_end;
   logic [VCNT_W-1:0] s_f1_vact_beg, s_f1_vact_end, s_f1_vs_beg, s_f1_vs_end;
   logic              s_hs_pol, s_vs_pol, s_ilace;

   assign cfg_bus = {cfg_line_len, cfg_hact_beg, cfg_hs_beg, cfg_hs_end, cfg_f1_vs_off,
                     cfg_f0_vact_beg, cfg_f0_vact_end, cfg_f0_vs_beg, cfg_f0_vs_end,
                     cfg_f1_vact_beg, cfg_f1_vact_end, cfg_f1_vs_beg, cfg_f1_vs_end,
                     cfg_hs_pol, cfg_vs_pol, cfg_ilace};

   assign {s_line_len, s_hact_beg, s_hs_beg, s_hs_end, s_f1_vs_off,
           s_f0_vact_beg, s_f0_vact_end, s_f0_vs_beg, s_f0_vs_end,
           s_f1_vact_beg, s_f1_vact_end, s_f1_vs_beg, s_f1_vs_end,
           s_hs_pol, s_vs_pol, s_ilace} = cfg_q;

   // Load while idle, and on the wrap out of the last pixel of a frame
   assign shadow_load = !en || frame_last;

   raster_cfg_shadow #(
      .W (CFG_W)
   ) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (shadow_load),
      .d     (cfg_bus),
      .q     (cfg_q)
   );

   // ---------------- raster counters ----------------
   logic              ilace_eff;
   logic [VCNT_W-1:0] frame_len;
   logic [HCNT_W-1:0] h_cnt;
   logic [VCNT_W-1:0] v_cnt;

   assign ilace_eff = ILACE_EN && s_ilace;
   assign frame_len = ilace_eff ? s_f1_vact_end : s_f0_vact_end;

   raster_counter #(
      .HCNT_W (HCNT_W),
      .VCNT_W (VCNT_W)
   ) u_counter (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (en),
      .line_len     (s_line_len),
      .frame_len    (frame_len),
      .h_o          (h_cnt),
      .v_o          (v_cnt),
      .frame_last_o (frame_last)
   );

   // ---------------- window decode ----------------
   tg_flags_t flags;

   raster_decode #(
      .HCNT_W   (HCNT_W),
      .VCNT_W   (VCNT_W),
      .ILACE_EN (ILACE_EN)
   ) u_decode (
      .h           (h_cnt),
      .v           (v_cnt),
      .hact_beg    (s_hact_beg),
      .hs_beg      (s_hs_beg),
      .hs_end      (s_hs_end),
      .f1_vs_off   (s_f1_vs_off),
      .f0_vact_beg (s_f0_vact_beg),
      .f0_vact_end (s_f0_vact_end),
      .f0_vs_beg   (s_f0_vs_beg),
      .f0_vs_end   (s_f0_vs_end),
      .f1_vact_beg (s_f1_vact_beg),
      .f1_vact_end (s_f1_vact_end),
      .f1_vs_beg   (s_f1_vs_beg),
      .f1_vs_end   (s_f1_vs_end),
      .ilace       (ilace_eff),
      .flags       (flags)
   );

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o <= 1'b0;
         vsync_o <= 1'b0;
         de_o    <= 1'b0;
         field_o <= FIELD_FIRST;
      end else if (!en) begin
         hsync_o <= pin_level(1'b0, s_hs_pol);
         vsync_o <= pin_level(1'b0, s_vs_pol);
         de_o    <= 1'b0;
         field_o <= FIELD_FIRST;
      end else begin
         hsync_o <= pin_level(flags.hs, s_hs_pol);
         vsync_o <= pin_level(flags.vs, s_vs_pol);
         de_o    <= flags.de;
         field_o <= flags.fld;
      end
   end

   // Disabled: no enable, first field, hsync at its resting level
   p_idle_out_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!de_o && !field_o && hsync_o == $past(s_hs_pol)));

   // Data-enable never before the horizontal active start
   p_de_hact_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> $past(h_cnt) >= $past(s_hact_beg));

   // Second field only exists in interlaced mode
   p_field_prog_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      field_o |-> $past(s_ilace));

   // Second-field data-enable lies inside the second active window
   p_f1_de_win_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (de_o && field_o) |-> ($past(v_cnt) >= $past(s_f1_vact_beg) &&
                             $past(v_cnt) <  $past(s_f1_vact_end)));

   // First-field data-enable lies inside the first active window
   p_f0_de_win_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (de_o && !field_o) |-> ($past(v_cnt) >= $past(s_f0_vact_beg) &&
                              $past(v_cnt) <  $past(s_f0_vact_end)));

endmodule

// File: tb/raster_tgen_tb_top.sv
module raster_tgen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HW = 12;
   localparam int VW = 11;

   typedef struct {
      int line_len; int hact_beg; int hs_beg; int hs_end; int off;
      int hs_pol;   int vs_pol;   int ilace;
      int f0vb; int f0ve; int f0sb; int f0se;
      int f1vb; int f1ve; int f1sb; int f1se;
   } tcfg_t;

   logic  clk = 1'b0;
   logic  rst_n = 1'b0;
   logic  en = 1'b0;
   tcfg_t cfg;
   tcfg_t mcfg;
   int    mh, mv;
   int    n_vec, n_bad;
   bit    done;

   logic hsync, vsync, de, field;

   always #(CLK_PERIOD / 2) clk = ~clk;

   raster_tgen #(
      .HCNT_W (HW),
      .VCNT_W (VW)
   ) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .en              (en),
      .cfg_line_len    (HW'(cfg.line_len)),
      .cfg_hact_beg    (HW'(cfg.hact_beg)),
      .cfg_hs_beg      (HW'(cfg.hs_beg)),
      .cfg_hs_end      (HW'(cfg.hs_end)),
      .cfg_f1_vs_off   (HW'(cfg.off)),
      .cfg_f0_vact_beg (VW'(cfg.f0vb)),
      .cfg_f0_vact_end (VW'(cfg.f0ve)),
      .cfg_f0_vs_beg   (VW'(cfg.f0sb)),
      .cfg_f0_vs_end   (VW'(cfg.f0se)),
      .cfg_f1_vact_beg (VW'(cfg.f1vb)),
      .cfg_f1_vact_end (VW'(cfg.f1ve)),
      .cfg_f1_vs_beg   (VW'(cfg.f1sb)),
      .cfg_f1_vs_end   (VW'(cfg.f1se)),
      .cfg_hs_pol      (1'(cfg.hs_pol)),
      .cfg_vs_pol      (1'(cfg.vs_pol)),
      .cfg_ilace       (1'(cfg.ilace)),
      .hsync_o         (hsync),
      .vsync_o         (vsync),
      .de_o            (de),
      .field_o         (field)
   );

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s at t=%0t: got %b expected %b", req, what, $time, got, exp);
      end
   endtask

   // Expected {hs, vs, de, fld} from the requirements, for position (h, v)
   function automatic logic [3:0] model_out(input tcfg_t c, input int h, input int v);
      logic fld, hs_a, vs_a, de_a, vact;
      int   mid;
      mid  = c.hs_beg + c.off;
      fld  = (c.ilace != 0) && (v >= c.f0ve);                       // R7
      hs_a = (h >= c.hs_beg) && (h < c.hs_end);                     // R2
      vact = fld ? (v >= c.f1vb && v < c.f1ve) : (v >= c.f0vb && v < c.f0ve); // R5 R8
      de_a = (h >= c.hact_beg) && vact;                             // R3
      if (fld)                                                      // R9
         vs_a = ((v > c.f1sb) || (v == c.f1sb && h >= mid)) &&
                ((v < c.f1se) || (v == c.f1se && h < mid));
      else                                                          // R4
         vs_a = (v >= c.f0sb) && (v < c.f0se);
      return {hs_a ^ 1'(c.hs_pol), vs_a ^ 1'(c.vs_pol), de_a, fld}; // R6
   endfunction

   // Advance n pixel clocks, comparing every output after each edge
   task automatic run_cycles(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [3:0] e;
         logic       was_en;
         int         flen;
         was_en = en;
         if (was_en) e = model_out(mcfg, mh, mv);
         else        e = {1'(mcfg.hs_pol), 1'(mcfg.vs_pol), 2'b00};
         flen = (mcfg.ilace != 0) ? mcfg.f1ve : mcfg.f0ve;
         if (!was_en) begin
            mh = 0; mv = 0; mcfg = cfg;
         end else if (mh == mcfg.line_len - 1) begin
            mh = 0;
            if (mv == flen - 1) begin mv = 0; mcfg = cfg; end
            else mv++;
         end else begin
            mh++;
         end
         @(posedge clk);
         @(negedge clk);
         if (!was_en) begin
            chk({tag, " R1"}, "hsync idle", hsync, e[3]);
            chk({tag, " R1"}, "vsync idle", vsync, e[2]);
            chk({tag, " R1"}, "de idle",    de,    e[1]);
            chk({tag, " R1"}, "field idle", field, e[0]);
         end else begin
            chk({tag, " R2 R6"}, "hsync", hsync, e[3]);
            chk({tag, e[0] ? " R9" : " R4"}, "vsync", vsync, e[2]);
            chk({tag, e[0] ? " R8" : " R5"}, "de", de, e[1]);
            chk({tag, " R7"}, "field", field, e[0]);
         end
      end
   endtask

   function automatic tcfg_t prog_cfg();
      tcfg_t c;
      c.line_len = 20; c.hact_beg = 6; c.hs_beg = 2; c.hs_end = 5; c.off = 3;
      c.hs_pol = 1; c.vs_pol = 1; c.ilace = 0;
      c.f0vb = 4; c.f0ve = 12; c.f0sb = 1; c.f0se = 3;
      c.f1vb = 2; c.f1ve = 30; c.f1sb = 5; c.f1se = 7;   // ignored when progressive
      return c;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "hsync in reset", hsync, 1'b0);
      chk("R1", "vsync in reset", vsync, 1'b0);
      chk("R1", "de in reset",    de,    1'b0);
      chk("R1", "field in reset", field, 1'b0);
      cfg = prog_cfg();
      rst_n = 1'b1;
      run_cycles(3, "reset");
   endtask

   task automatic t_progressive();
      en = 1'b1;
      run_cycles(2 * 240 + 7, "R3 progressive");
      en = 1'b0;
      run_cycles(2, "R5 stop");
   endtask

   task automatic t_polarity();
      cfg.hs_pol = 0; cfg.vs_pol = 0;
      run_cycles(2, "R6 load");
      en = 1'b1;
      run_cycles(240, "R6 active-high");
      en = 1'b0;
      run_cycles(2, "R6 stop");
   endtask

   task automatic t_interlace();
      cfg.line_len = 24; cfg.hact_beg = 8; cfg.hs_beg = 2; cfg.hs_end = 5; cfg.off = 12;
      cfg.hs_pol = 0; cfg.vs_pol = 1; cfg.ilace = 1;
      cfg.f0vb = 3;  cfg.f0ve = 10; cfg.f0sb = 1;  cfg.f0se = 3;
      cfg.f1vb = 14; cfg.f1ve = 21; cfg.f1sb = 11; cfg.f1se = 13;
      run_cycles(2, "R7 load");
      en = 1'b1;
      run_cycles(2 * 504 + 5, "R7 R8 R9 interlaced");
      en = 1'b0;
      run_cycles(2, "R9 stop");
   endtask

   task automatic t_midframe();
      cfg = prog_cfg();
      run_cycles(2, "R10 load");
      en = 1'b1;
      run_cycles(100, "R10 before change");
      cfg.line_len = 16; cfg.hact_beg = 4; cfg.hs_beg = 1; cfg.hs_end = 3; cfg.f0ve = 9;
      run_cycles(600, "R10 after change");
   endtask

   task automatic t_disable();
      run_cycles(37, "R1 running");
      en = 1'b0;
      run_cycles(3, "R1 disabled");
      en = 1'b1;
      run_cycles(200, "R1 restart");
      en = 1'b0;
      run_cycles(2, "R1 end");
   endtask

   initial begin
      n_vec = 0; n_bad = 0; done = 1'b0;
      mh = 0; mv = 0;
      repeat (3) @(posedge clk);
      t_reset();
      t_progressive();
      t_polarity();
      t_interlace();
      t_midframe();
      t_disable();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule